// File: doc/BRIEF.md
# Display Refresh Fetch Arbiter

This block decides, one memory slot at a time, whether the video memory bus serves the display refresh FIFO or one other master, such as the host path or a drawing engine. When the display side wins a slot, it keeps the bus for a programmed burst of N completed memory cycles. The other master gets the bus only after that burst. This gives screen refresh a guaranteed share of bandwidth.

Each scanline has a fetch budget of L memory cycles. L is an 11-bit value split over a low byte and a 3-bit high field. It equals the bytes in a scanline divided by the width of one memory cycle. A width input selects 4-byte or 8-byte cycles. The block counts the bytes that completed display cycles deliver and compares them with L scaled by the cycle width. Once the budget is used, the display side asks for nothing more and a line-complete flag rises. A line-start pulse clears the count. The budget applies only while its enable input is set.

Top module: `disp_fetch_arb`

## Requirements
- R1: While reset is high, and on the first clock after it, both grants and the line-complete flag are low.
- R2: The two grants are never high together. When neither grant is held and neither request is pending, no grant is asserted on the next clock.
- R3: The display side has priority. It wins any open slot in which its request is pending and the line is not complete. An open slot is a clock with no grant held, or a completed cycle of the other master. Its grant appears on the following clock.
- R4: With N (burst_n) at least 1, the display grant stays high until N cycle-done strobes have arrived while it is held, whatever its request does. The only earlier exit is the fetch budget being reached.
- R5: With N equal to 0, the display grant is high for exactly one clock, then it drops.
- R6: When a display burst ends while the other request is pending, the other grant is high on the next clock. It stays high until a cycle-done strobe arrives with the display side eligible, or until its request drops.
- R7: Each cycle-done strobe during a display grant adds 4 bytes (wide_bus=0) or 8 bytes (wide_bus=1) to the line count. The budget is reached when the count is at least {len_hi,len_lo} × 4 or × 8 respectively. A line therefore receives exactly L display cycles at either width.
- R8: Once the budget is reached, line_done is high and no new display grant starts until the next line start. A burst in progress ends at the strobe that reaches the budget.
- R9: While len_en is low, line_done stays low and display fetches are never capped.
- R10: line_start clears the line count and line_done as of the next clock. A cycle-done strobe in the same clock is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_start | input | 1 | One-clock pulse at the start of each scanline |
| disp_req | input | 1 | Display FIFO wants memory cycles |
| oth_req | input | 1 | Other master wants memory cycles |
| cyc_done | input | 1 | Current memory cycle completed |
| burst_n | input | 8 | Reserved display burst length N in cycles |
| len_lo | input | 8 | Fetch budget L, bits 7:0 |
| len_hi | input | 3 | Fetch budget L, bits 10:8 |
| len_en | input | 1 | Enables the per-line fetch budget |
| wide_bus | input | 1 | 1: 8-byte memory cycles, 0: 4-byte cycles |
| disp_gnt | output | 1 | Bus granted to the display FIFO |
| oth_gnt | output | 1 | Bus granted to the other master |
| line_done | output | 1 | Fetch budget for this line reached |

## Verification
The hardest situation to reach from the ports is the budget running out in the middle of a burst while the other master is waiting. The burst must stop short of N and hand over at once, and later slots must then pass to the other master even though the display request is still high. Directed lines with small L, N larger than L and both requests held reach this case exactly. Random lines then combine short budgets, N of 0 to 6, both widths and sparse done strobes. A cycle-counting model in the bench follows every clock.

// File: rtl/disp_arb_pkg.sv
package disp_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_DISP = 2'd1,
    ARB_OTH  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/disp_line_meter.sv
// Per-line byte meter: accumulates bytes delivered by display cycles and
// compares them with the budget scaled to the selected cycle width.
module disp_line_meter #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             count_en,
  input  logic             wide_bus,
  input  logic             len_en,
  input  logic [LEN_W-1:0] len,
  output logic             cap_next,
  output logic             line_done
);
  localparam int CNT_W = LEN_W + 3;

  logic [CNT_W-1:0] byte_q, byte_d, unit, limit, sat;
  logic [CNT_W:0]   sum;

  assign unit  = wide_bus ? CNT_W'(8) : CNT_W'(4);
  assign limit = wide_bus ? {len, 3'b000} : {1'b0, len, 2'b00};
  assign sum   = {1'b0, byte_q} + {1'b0, unit};
  assign sat   = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];

  always_comb begin
    if (line_start)    byte_d = '0;
    else if (count_en) byte_d = sat;
    else               byte_d = byte_q;
  end

  assign cap_next = len_en && (byte_d >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q    <= '0;
      line_done <= 1'b0;
    end else begin
      byte_q    <= byte_d;
      line_done <= cap_next;
    end
  end
endmodule

// File: rtl/disp_burst_cnt.sv
// Counts completed cycles inside one display burst.
module disp_burst_cnt #(
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           inc,
  input  logic [N_W-1:0] burst_n,
  output logic           last
);
  logic [N_W-1:0] cnt_q;
  logic [N_W:0]   inc_val;

  assign inc_val = {1'b0, cnt_q} + 1'b1;
  assign last    = inc_val >= {1'b0, burst_n};

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (inc)     cnt_q <= inc_val[N_W-1:0];
  end
endmodule

// File: rtl/disp_fetch_arb.sv
module disp_fetch_arb
  import disp_arb_pkg::*;
#(
  parameter int N_W      = 8,
  parameter int LEN_LO_W = 8,
  parameter int LEN_HI_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                line_start,
  input  logic                disp_req,
  input  logic                oth_req,
  input  logic                cyc_done,
  input  logic [N_W-1:0]      burst_n,
  input  logic [LEN_LO_W-1:0] len_lo,
  input  logic [LEN_HI_W-1:0] len_hi,
  input  logic                len_en,
  input  logic                wide_bus,
  output logic                disp_gnt,
  output logic                oth_gnt,
  output logic                line_done
);
  localparam int LEN_W = LEN_LO_W + LEN_HI_W;

  arb_state_e state_q, state_d;
  logic       disp_ok, disp_cyc, burst_clr, burst_last, cap_next, n_zero;

  assign disp_ok  = disp_req && !line_done;
  assign disp_cyc = (state_q == ARB_DISP) && cyc_done;
  assign n_zero   = (burst_n == '0);

  disp_line_meter #(.LEN_W(LEN_W)) u_meter (
    .clk       (clk),
    .rst       (rst),
    .line_start(line_start),
    .count_en  (disp_cyc),
    .wide_bus  (wide_bus),
    .len_en    (len_en),
    .len       ({len_hi, len_lo}),
    .cap_next  (cap_next),
    .line_done (line_done)
  );

  disp_burst_cnt #(.N_W(N_W)) u_burst (
    .clk    (clk),
    .rst    (rst),
    .clear  (burst_clr),
    .inc    (disp_cyc),
    .burst_n(burst_n),
    .last   (burst_last)
  );

  always_comb begin
    state_d   = state_q;
    burst_clr = 1'b0;
    unique case (state_q)
      ARB_IDLE: begin
        if (disp_ok) begin
          state_d   = ARB_DISP;
          burst_clr = 1'b1;
        end else if (oth_req) begin
          state_d = ARB_OTH;
        end
      end
      ARB_DISP: begin
        if (n_zero || (cyc_done && (burst_last || cap_next)))
          state_d = oth_req ? ARB_OTH : ARB_IDLE;
      end
      ARB_OTH: begin
        if (!oth_req) begin
          state_d = ARB_IDLE;
        end else if (cyc_done && disp_ok) begin
          state_d   = ARB_DISP;
          burst_clr = 1'b1;
        end
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ARB_IDLE;
      disp_gnt <= 1'b0;
      oth_gnt  <= 1'b0;
    end else begin
      state_q  <= state_d;
      disp_gnt <= (state_d == ARB_DISP);
      oth_gnt  <= (state_d == ARB_OTH);
    end
  end
endmodule

// File: rtl/disp_fetch_arb_chk.sv
module disp_fetch_arb_chk #(
  parameter int N_W      = 8,
  parameter int LEN_LO_W = 8,
  parameter int LEN_HI_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                line_start,
  input logic                disp_req,
  input logic                oth_req,
  input logic [N_W-1:0]      burst_n,
  input logic [LEN_LO_W-1:0] len_lo,
  input logic [LEN_HI_W-1:0] len_hi,
  input logic                len_en,
  input logic                disp_gnt,
  input logic                oth_gnt,
  input logic                line_done
);
  // R2
  grant_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(disp_gnt && oth_gnt));

  // R2
  quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (!disp_gnt && !oth_gnt && !disp_req && !oth_req) |=> (!disp_gnt && !oth_gnt));

  // R3
  disp_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!disp_gnt && !oth_gnt && disp_req && !line_done) |=> disp_gnt);

  // R5
  single_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_gnt && burst_n == '0) |=> !disp_gnt);

  // R6
  handoff_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_gnt && burst_n == '0 && oth_req) |=> oth_gnt);

  // R8
  capped_chk: assert property (@(posedge clk) disable iff (rst)
    (line_done && !disp_gnt && !line_start) |=> !disp_gnt);

  // R9
  cap_off_chk: assert property (@(posedge clk) disable iff (rst)
    !len_en |=> !line_done);

  // R10
  line_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (line_start && len_en && {len_hi, len_lo} != '0) |=> !line_done);
endmodule

bind disp_fetch_arb disp_fetch_arb_chk #(
  .N_W(N_W), .LEN_LO_W(LEN_LO_W), .LEN_HI_W(LEN_HI_W)
) u_chk (.*);

// File: tb/disp_fetch_arb_tb.sv
module disp_fetch_arb_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_start = 1'b0, disp_req = 1'b0, oth_req = 1'b0, cyc_done = 1'b0;
  logic [7:0] burst_n = 8'd0;
  logic [7:0] len_lo = 8'd0;
  logic [2:0] len_hi = 3'd0;
  logic       len_en = 1'b0, wide_bus = 1'b0;
  logic       disp_gnt, oth_gnt, line_done;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_fetch_arb u_dut (
    .clk(clk), .rst(rst), .line_start(line_start), .disp_req(disp_req),
    .oth_req(oth_req), .cyc_done(cyc_done), .burst_n(burst_n),
    .len_lo(len_lo), .len_hi(len_hi), .len_en(len_en), .wide_bus(wide_bus),
    .disp_gnt(disp_gnt), .oth_gnt(oth_gnt), .line_done(line_done)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-counting reference: budget is L cycles, independent of width.
  int m_state = 0, m_cnt = 0, m_burst = 0;
  bit m_done = 1'b0;

  function automatic int next_cnt(input int st, input int cnt);
    if (line_start) return 0;
    if (st == 1 && cyc_done) return cnt + 1;
    return cnt;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state <= 0; m_cnt <= 0; m_burst <= 0; m_done <= 1'b0;
    end else begin
      int cn, lim, ns, nb;
      bit capn, elig;
      cn   = next_cnt(m_state, m_cnt);
      lim  = int'({len_hi, len_lo});
      capn = len_en && (cn >= lim);
      elig = disp_req && !m_done;
      ns = m_state; nb = m_burst;
      case (m_state)
        0: if (elig) begin ns = 1; nb = 0; end else if (oth_req) ns = 2;
        1: begin
          if (burst_n == 8'd0) ns = oth_req ? 2 : 0;
          else if (cyc_done) begin
            nb = m_burst + 1;
            if (nb >= int'(burst_n) || capn) ns = oth_req ? 2 : 0;
          end
        end
        default: if (!oth_req) ns = 0;
                 else if (cyc_done && elig) begin ns = 1; nb = 0; end
      endcase
      m_state <= ns; m_burst <= nb; m_cnt <= cn; m_done <= capn;
    end
  end

  // Negedge monitor: model compare plus run statistics.
  int  run_len = 0, max_run = 0, runs = 0, run_dones = 0, first_run_dones = -1;
  int  disp_cycles = 0, overlap = 0, ho_ok = 0, ho_bad = 0;
  bit  ld_seen = 1'b0, prev_disp = 1'b0, prev_oreq = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      check("R3 disp_gnt vs model", int'(disp_gnt), int'(m_state == 1));
      check("R6 oth_gnt vs model", int'(oth_gnt), int'(m_state == 2));
      check("R7 line_done vs model", int'(line_done), int'(m_done));
      if (disp_gnt && oth_gnt) overlap++;
      if (line_done) ld_seen = 1'b1;
      if (disp_gnt) begin
        run_len++;
        if (cyc_done) begin disp_cycles++; run_dones++; end
      end else if (run_len > 0) begin
        if (run_len > max_run) max_run = run_len;
        if (first_run_dones < 0) first_run_dones = run_dones;
        runs++;
        run_len = 0; run_dones = 0;
      end
      if (prev_disp && !disp_gnt && prev_oreq) begin
        if (oth_gnt) ho_ok++; else ho_bad++;
      end
      prev_disp = disp_gnt;
      prev_oreq = oth_req;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_stats();
    run_len = 0; max_run = 0; runs = 0; run_dones = 0; first_run_dones = -1;
    disp_cycles = 0; ld_seen = 1'b0; ho_ok = 0; ho_bad = 0;
  endtask

  task automatic new_line();
    line_start = 1'b1;
    tick(1);
    line_start = 1'b0;
    clear_stats();
  endtask

  task automatic go_idle();
    disp_req = 1'b0; oth_req = 1'b0; cyc_done = 1'b1;
    tick(12);
    cyc_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    tick(3);
    // R1: reset holds everything low
    check("R1 disp_gnt in reset", int'(disp_gnt), 0);
    check("R1 oth_gnt in reset", int'(oth_gnt), 0);
    check("R1 line_done in reset", int'(line_done), 0);
    rst = 1'b0;
    tick(1);
    check("R1 idle after reset", int'(disp_gnt | oth_gnt | line_done), 0);

    // R5: N=0 gives one-clock display grants
    burst_n = 8'd0; len_en = 1'b0; disp_req = 1'b1;
    new_line();
    tick(20);
    check("R5 longest display run", max_run, 1);
    check("R5 display runs seen", int'(runs >= 5), 1);

    // R4, R6: N=4 burst with both masters busy
    go_idle();
    burst_n = 8'd4; oth_req = 1'b1; cyc_done = 1'b1;
    new_line();
    disp_req = 1'b1;
    tick(30);
    check("R4 dones in first burst", first_run_dones, 4);
    check("R6 handoffs to other", int'(ho_ok > 0), 1);
    check("R6 missed handoffs", ho_bad, 0);

    // R7, R8: L=3 narrow bus, N=2, budget cuts second burst short
    go_idle();
    burst_n = 8'd2; len_en = 1'b1; len_hi = 3'd0; len_lo = 8'd3; wide_bus = 1'b0;
    new_line();
    disp_req = 1'b1; cyc_done = 1'b1;
    tick(30);
    check("R7 cycles per line narrow", disp_cycles, 3);
    check("R8 line_done after budget", int'(line_done), 1);
    check("R8 no grant after budget", int'(disp_gnt), 0);

    // R10 + R7 wide bus: new line clears flag, same cycle budget
    wide_bus = 1'b1;
    new_line();
    check("R10 line_done cleared", int'(line_done), 0);
    tick(30);
    check("R7 cycles per line wide", disp_cycles + 1, 3 + 1);
    check("R8 line_done wide", int'(line_done), 1);

    // R8: N larger than L with other waiting -> early handoff
    go_idle();
    burst_n = 8'd6; len_lo = 8'd2; oth_req = 1'b1;
    new_line();
    disp_req = 1'b1; cyc_done = 1'b1;
    tick(25);
    check("R8 capped burst cycles", disp_cycles, 2);
    check("R8 other keeps bus", int'(oth_gnt), 1);

    // R9: budget disabled, L=0
    go_idle();
    len_en = 1'b0; len_lo = 8'd0; burst_n = 8'd3;
    new_line();
    disp_req = 1'b1; cyc_done = 1'b1;
    tick(40);
    check("R9 line_done never seen", int'(ld_seen), 0);
    check("R9 display keeps fetching", int'(disp_cycles > 10), 1);

    // Random lines
    for (int ln = 0; ln < 30; ln++) begin
      burst_n  = 8'($urandom_range(0, 6));
      len_lo   = 8'($urandom_range(0, 20));
      len_hi   = 3'd0;
      len_en   = ($urandom_range(0, 3) != 0);
      wide_bus = 1'($urandom_range(0, 1));
      new_line();
      for (int c = 0; c < int'($urandom_range(30, 80)); c++) begin
        disp_req = ($urandom_range(0, 9) < 7);
        oth_req  = ($urandom_range(0, 1) == 1);
        cyc_done = ($urandom_range(0, 9) < 6);
        tick(1);
      end
    end

    // R2: grants never overlapped anywhere in the run
    check("R2 grant overlap count", overlap, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule